// File: doc/BRIEF.md
# Binary Template Bit Correlator

This block scores an 8x8 binary template against a binary image whose pixels arrive packed sixteen to a word. Each accepted word pairs one template row (eight bits, one byte) with sixteen horizontally adjacent image bits. A single loaded word is reused for eight consecutive candidate offsets. In each scan cycle the block masks the top byte of a shifting copy of the word with the template row and counts the surviving ones in an adder tree. It then moves the copy one bit to the left, so the next cycle scores the next offset.

One word is supplied per template row, eight words in all. The per-offset counts of all eight rows add into eight running sums. After the last offset of the eighth row, the block registers the eight sums and raises a one-cycle completion pulse. It then starts the next frame from zero. Pixel thresholding and template storage are handled elsewhere.

Top module: `bit_template_corr`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `done` is 0 and every field of `sums` is 0.
- R2: `in_ready` is 1 when the block is idle, or when it is scoring its eighth offset. It is 0 otherwise, and an `in_valid` seen while `in_ready` is 0 changes neither the sums nor the timing.
- R3: For offset p (0 to 7), the score of a word is the number of ones in `img_word[15-p:8-p] & tmpl_row`. Bit 15 of `img_word` lines up with bit 7 of `tmpl_row`.
- R4: A word taken at clock edge E is scored at offsets 0 to 7 on edges E+1 to E+8. A word offered in the eighth scoring cycle is taken at once, so words can follow each other with no idle cycle.
- R5: The sum for offset p is the total of its scores over the eight words of a frame. It is 7 bits wide (0 to 64) and sits at `sums[7*p+6:7*p]`.
- R6: `done` is 1 for exactly one cycle, on the edge after the eighth offset of the eighth word. `sums` takes its new value on that same edge and holds it until the next `done`.
- R7: Each frame's sums start from zero, with nothing carried over from the frame before.
- R8: A reset in the middle of a frame discards its partial sums, and the next full frame is scored as if it were the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An image word and template row are offered |
| in_ready | output | 1 | An offered word would be taken on this edge |
| img_word | input | 16 | Packed image bits, bit 15 leftmost |
| tmpl_row | input | 8 | Packed template row, bit 7 leftmost |
| done | output | 1 | One-cycle pulse: a frame's sums are ready |
| sums | output | 56 | Eight 7-bit sums, offset p at bits 7p+6..7p |

## Verification
Two cases are hard to reach from the ports. The first is a word that arrives in exactly the eighth scoring cycle, where the new load and the last shift of the old word fall on the same edge. The second is an `in_valid` that arrives while the block is busy and must be ignored. The bench drives both through a word-sending task: in one mode it offers each word the moment `in_ready` rises, back to back, and in the other it holds `in_valid` high with random data throughout the busy cycles. A behavioural model checks the ready flag, the pulse and all eight sums on every clock, and directed frames with known shift patterns pin down the offset order. A reset in the middle of a frame is followed by a known frame, to show that no partial sum survives.

// File: rtl/bc_pkg.sv
package bc_pkg;

    // Scan phase of the correlator sequencer
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;

endpackage

// File: rtl/bc_ones_tree.sv
// Adder-tree population count over N bits
module bc_ones_tree #(
    parameter int N = 8
) (
    input  logic [N-1:0]            bits,
    output logic [$clog2(N+1)-1:0]  count
);
    localparam int CW = $clog2(N + 1);
    localparam int LV = (N > 1) ? $clog2(N) : 0;
    localparam int PN = 1 << LV;

    // Heap layout: leaves at PN-1 .. 2*PN-2, root at 0
    logic [CW-1:0] part [2*PN-1];

    always_comb begin
        for (int i = 0; i < PN; i++) begin
            if (i < N) begin
                part[PN-1+i] = CW'(bits[i]);
            end else begin
                part[PN-1+i] = '0;
            end
        end
        for (int k = PN - 2; k >= 0; k--) begin
            part[k] = part[2*k+1] + part[2*k+2];
        end
        count = part[0];
    end

endmodule

// File: rtl/bc_scan_ctrl.sv
// Word intake, one-bit shift window and offset/row sequencing
module bc_scan_ctrl
    import bc_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int ROW_W     = 8,
    parameter int POSITIONS = 8,
    parameter int ROWS      = 8,
    localparam int PW = (POSITIONS > 1) ? $clog2(POSITIONS) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] img_word,
    input  logic [ROW_W-1:0]  tmpl_row,
    output logic              in_ready,
    output logic              step,
    output logic [PW-1:0]     step_pos,
    output logic              frame_end,
    output logic [ROW_W-1:0]  window
);
    localparam logic [PW-1:0] POS_LAST = PW'(POSITIONS - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [WORD_W-1:0] sh;
        logic [ROW_W-1:0]  tmpl;
        logic [PW-1:0]     pos;
        logic [RW-1:0]     row;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  last_pos;
    logic  take;

    always_comb begin
        last_pos = (scan_q.phase == PH_SCAN) && (scan_q.pos == POS_LAST);
        in_ready = (scan_q.phase == PH_IDLE) || last_pos;
        take     = in_valid && in_ready;
        scan_d   = scan_q;

        if (scan_q.phase == PH_SCAN) begin
            scan_d.sh  = {scan_q.sh[WORD_W-2:0], 1'b0};
            scan_d.pos = scan_q.pos + PW'(1);
            if (last_pos) begin
                scan_d.phase = PH_IDLE;
                scan_d.pos   = '0;
                scan_d.row   = (scan_q.row == ROW_LAST) ? '0 : scan_q.row + RW'(1);
            end
        end

        if (take) begin
            scan_d.phase = PH_SCAN;
            scan_d.sh    = img_word;
            scan_d.tmpl  = tmpl_row;
            scan_d.pos   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign step      = (scan_q.phase == PH_SCAN);
    assign step_pos  = scan_q.pos;
    assign frame_end = last_pos && (scan_q.row == ROW_LAST);
    assign window    = scan_q.sh[WORD_W-1 -: ROW_W] & scan_q.tmpl;

    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
        (step && !last_pos) |=> (scan_q.sh == ($past(scan_q.sh) << 1))) else $error("shift"); // R4
    AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !last_pos) |=> (step && (step_pos == $past(step_pos) + PW'(1)))) else $error("pos"); // R4
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> $stable(scan_q.tmpl)) else $error("ignore"); // R2

endmodule

// File: rtl/bc_acc_bank.sv
// Per-offset running sums and the registered frame result
module bc_acc_bank #(
    parameter int ROW_W     = 8,
    parameter int POSITIONS = 8,
    parameter int ROWS      = 8,
    localparam int PW = (POSITIONS > 1) ? $clog2(POSITIONS) : 1,
    localparam int CW = $clog2(ROW_W + 1),
    localparam int SW = $clog2(ROW_W * ROWS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step,
    input  logic [PW-1:0]           step_pos,
    input  logic [CW-1:0]           count,
    input  logic                    frame_end,
    output logic [POSITIONS*SW-1:0] sums,
    output logic                    done
);
    typedef struct packed {
        logic [SW-1:0] acc;
        logic [SW-1:0] res;
    } lane_t;

    logic done_d, done_q;

    for (genvar p = 0; p < POSITIONS; p++) begin : g_lane
        lane_t         lane_d, lane_q;
        logic          hit;
        logic [SW-1:0] grown;

        assign hit = step && (step_pos == PW'(p));

        always_comb begin
            grown  = lane_q.acc + (hit ? SW'(count) : '0);
            lane_d = lane_q;
            lane_d.acc = grown;
            if (frame_end) begin
                lane_d.res = grown;
                lane_d.acc = '0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign sums[p*SW +: SW] = lane_q.res;

        AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
            (lane_q.acc <= SW'(ROW_W * ROWS))) else $error("bound"); // R5
        AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
            frame_end |=> (lane_q.acc == '0)) else $error("clear"); // R7
    end

    always_comb begin
        done_d = frame_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_d;
        end
    end

    assign done = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("pulse"); // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(sums)) else $error("hold"); // R6

endmodule

// File: rtl/bit_template_corr.sv
// Binary template bit correlator: top level
module bit_template_corr #(
    parameter int WORD_W    = 16,
    parameter int ROW_W     = 8,
    parameter int POSITIONS = 8,
    parameter int ROWS      = 8,
    localparam int SW = $clog2(ROW_W * ROWS + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [WORD_W-1:0]       img_word,
    input  logic [ROW_W-1:0]        tmpl_row,
    output logic                    done,
    output logic [POSITIONS*SW-1:0] sums
);
    localparam int PW = (POSITIONS > 1) ? $clog2(POSITIONS) : 1;
    localparam int CW = $clog2(ROW_W + 1);

    logic             step;
    logic [PW-1:0]    step_pos;
    logic             frame_end;
    logic [ROW_W-1:0] window;
    logic [CW-1:0]    count;

    bc_scan_ctrl #(
        .WORD_W(WORD_W), .ROW_W(ROW_W), .POSITIONS(POSITIONS), .ROWS(ROWS)
    ) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .img_word(img_word),
        .tmpl_row(tmpl_row), .in_ready(in_ready), .step(step),
        .step_pos(step_pos), .frame_end(frame_end), .window(window)
    );

    bc_ones_tree #(.N(ROW_W)) u_tree (
        .bits(window), .count(count)
    );

    bc_acc_bank #(
        .ROW_W(ROW_W), .POSITIONS(POSITIONS), .ROWS(ROWS)
    ) u_bank (
        .clk(clk), .rst(rst), .step(step), .step_pos(step_pos),
        .count(count), .frame_end(frame_end), .sums(sums), .done(done)
    );

    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !done)) else $error("reset"); // R1
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (count <= CW'(ROW_W))) else $error("count"); // R3

endmodule

// File: tb/bit_template_corr_test.sv
module bit_template_corr_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] img_word = '0;
    logic [7:0]  tmpl_row = '0;
    logic        done;
    logic [55:0] sums;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;

    always #2.5 clk = ~clk;

    bit_template_corr uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .img_word(img_word), .tmpl_row(tmpl_row), .done(done), .sums(sums)
    );

    // behavioural reference model
    bit m_busy = 0;
    int m_pos = 0, m_row = 0, m_word = 0, m_tmpl = 0, m_c = 0;
    bit m_done = 0, m_rdy = 0, m_take = 0;
    int m_acc [8];
    int m_sums [8];

    function automatic int ones8(input int v);
        int n = 0;
        for (int b = 0; b < 8; b++) n += (v >> b) & 1;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_pos = 0; m_row = 0; m_done = 0;
            for (int p = 0; p < 8; p++) begin m_acc[p] = 0; m_sums[p] = 0; end
        end else begin
            m_rdy  = !m_busy || (m_pos == 7);
            m_take = in_valid && m_rdy;
            m_done = 0;
            if (m_busy) begin
                m_c = ones8(((m_word >> (8 - m_pos)) & 255) & m_tmpl);
                m_acc[m_pos] += m_c;
                if (m_pos == 7) begin
                    m_busy = 0;
                    m_pos = 0;
                    if (m_row == 7) begin
                        for (int p = 0; p < 8; p++) begin m_sums[p] = m_acc[p]; m_acc[p] = 0; end
                        m_done = 1;
                        m_row = 0;
                    end else m_row++;
                end else m_pos++;
            end
            if (m_take) begin
                m_busy = 1; m_pos = 0;
                m_word = int'(img_word); m_tmpl = int'(tmpl_row);
            end
        end
    end

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(in_ready == (!m_busy || m_pos == 7), "R2 in_ready", in_ready, (!m_busy || m_pos == 7));
            chk(done == m_done, "R6 done", done, m_done);
            for (int p = 0; p < 8; p++)
                chk(int'(sums[p*7 +: 7]) == m_sums[p], "R5 sums", sums[p*7 +: 7], m_sums[p]);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // send one frame of eight words; called at a negedge
    // gap: idle cycles before each word; junk: drive in_valid with noise while busy
    task automatic send_frame(input int gap, input bit junk, input bit fixed,
                              input logic [15:0] fw, input logic [7:0] ft, input bit mark);
        for (int r = 0; r < 8; r++) begin
            for (int g = 0; g < gap; g++) begin
                in_valid = junk && !in_ready;
                img_word = 16'($urandom); tmpl_row = 8'($urandom);
                @(negedge clk);
            end
            while (!in_ready) begin
                in_valid = junk;
                img_word = 16'($urandom); tmpl_row = 8'($urandom);
                @(negedge clk);
            end
            if (mark && r == 0) t0 = cyc + 1;
            in_valid = 1'b1;
            img_word = fixed ? fw : 16'($urandom);
            tmpl_row = fixed ? ft : 8'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(sums == '0, "R1 sums", sums, 0);

        // R3: top byte all ones, full template -> offset p sees 8-p ones per row
        send_frame(0, 0, 1, 16'hFF00, 8'hFF, 0);
        wait_done();
        for (int p = 0; p < 8; p++)
            chk(int'(sums[p*7 +: 7]) == 8 * (8 - p), "R3 FF00", sums[p*7 +: 7], 8 * (8 - p));
        @(negedge clk);
        chk(done == 1'b0, "R6 single pulse", done, 0);

        // R3/R2: low byte ones, noise on in_valid while busy -> offset p sees p ones per row
        send_frame(2, 1, 1, 16'h00FF, 8'hFF, 0);
        wait_done();
        for (int p = 0; p < 8; p++)
            chk(int'(sums[p*7 +: 7]) == 8 * p, "R2 R3 00FF ignore", sums[p*7 +: 7], 8 * p);

        // R4: back-to-back frame, done edge = first accept edge + 64
        @(negedge clk);
        send_frame(0, 0, 0, '0, '0, 1);
        wait_done();
        chk(cyc - t0 == 64, "R4 back-to-back latency", cyc - t0, 64);

        // R7: zero template frame right after -> all sums zero
        send_frame(0, 0, 1, 16'hFFFF, 8'h00, 0);
        wait_done();
        chk(sums == '0, "R7 fresh frame", sums, 0);

        // R8: reset inside a frame
        for (int r = 0; r < 3; r++) begin
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1; img_word = 16'hFFFF; tmpl_row = 8'hFF;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(in_ready == 1'b1 && done == 1'b0, "R8 reset idle", {in_ready, done}, 2);
        send_frame(1, 0, 1, 16'hFF00, 8'hFF, 0);
        wait_done();
        for (int p = 0; p < 8; p++)
            chk(int'(sums[p*7 +: 7]) == 8 * (8 - p), "R8 after reset", sums[p*7 +: 7], 8 * (8 - p));

        // random frames, mixed gaps and noise
        for (int f = 0; f < 12; f++) begin
            send_frame(f % 3, f[0], 0, '0, '0, 0);
            wait_done();
        end
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule